// File: doc/BRIEF.md
# Instruction/Data Field Address Extension

This unit lets a processor with a 12-bit address reach more than 4096 words of memory. It keeps two small registers, a data field and an instruction field, and puts one of them in front of each 12-bit address as the upper bits. Instruction fetches and direct operand accesses take the instruction field. Indirect load and store data accesses take the data field.

Software selects a new data field by writing a command word to the I/O port at the highest 12-bit address. The new field reaches indirect data accesses on the next cycle. It reaches the instruction stream only on the next taken jump, when the data field is copied into the instruction field. The I/O port address is always mapped with a field of zero, so the port can be reached from any field. The memory array and the processor's sequencing are outside this unit.

Top module: `mem_field_ext`

## Requirements
- R1: While reset is low at a rising edge, both fields clear to 0. After reset every extended address carries upper bits 0.
- R2: When `io_wr_i` is high and bits [11:10] of `io_wdata_i` equal 2'b11, the data field loads `io_wdata_i[FIELD_W-1:0]` at the clock edge. Indirect data accesses from the next cycle on use the new value.
- R3: A port write whose bits [11:10] are 00, 01 or 10, or any word presented while `io_wr_i` is low, leaves the data field unchanged. Bits [9:FIELD_W] of a field-command word have no effect.
- R4: Accesses with `acc_indirect_i` low use the instruction field. A data-field write alone does not change it.
- R5: A cycle with `jump_i` high copies the data field into the instruction field at the clock edge.
- R6: If a field-command write and a jump happen in the same cycle, the instruction field takes the old data field and the data field takes the written value.
- R7: When `addr_i` equals 12'hFFF, the upper FIELD_W bits of `ext_addr_o` are 0, whatever the fields hold and whatever the access kind.
- R8: `ext_addr_o[11:0]` always equals `addr_i`, combinationally in the same cycle.
- R9: Without a jump, the instruction field holds its value. Further jumps with no data-field change keep it equal to the data field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| io_wr_i | input | 1 | A write to the I/O port address happens this cycle |
| io_wdata_i | input | 12 | Word written to the I/O port |
| acc_indirect_i | input | 1 | The current access is an indirect load/store data access |
| jump_i | input | 1 | A jump is taken this cycle |
| addr_i | input | 12 | 12-bit address from the processor |
| ext_addr_o | output | 13 | Extended address: {field, addr_i} |

## Verification
The address path is tried with direct fetches and indirect data accesses after the two fields have been set apart. This shows which field each access kind selects. Port writes to the other device codes, and writes with stray middle bits, are compared against true field commands to show that only the device code 11 loads the data field. A jump with no write, a write with no jump, and both in one cycle separate the copy order. Accesses to 12'hFFF made from field 1 show that the port is reached at field 0.

// File: rtl/field_ext_pkg.sv
// Package: shared constants and types for the field address extension.
// Assumes the port word carries a 2-bit device code in its two top bits.
package field_ext_pkg;
    localparam logic [1:0] DEV_FIELD_CMD = 2'b11;   // device code of the field command

    typedef enum logic {
        SRC_INSTR = 1'b0,
        SRC_DATA  = 1'b1
    } field_src_e;
endpackage

// File: rtl/fx_cmd_decode.sv
// Module: decodes a port write into a data-field load request.
// Assumes the device code sits in the top two bits and the field in the low bits.
module fx_cmd_decode #(
    parameter int ADDR_W  = 12,
    parameter int FIELD_W = 1
) (
    input  logic               io_wr,
    input  logic [ADDR_W-1:0]  wdata,
    output logic               df_load,
    output logic [FIELD_W-1:0] df_next
);
    import field_ext_pkg::*;

    logic unused_mid_bits;

    // Purpose: load only on a write that addresses the field-command device.
    always_comb begin
        df_load = io_wr && (wdata[ADDR_W-1 -: 2] == DEV_FIELD_CMD);
        df_next = wdata[FIELD_W-1:0];
    end

    assign unused_mid_bits = ^wdata[ADDR_W-3:FIELD_W];
endmodule

// File: rtl/fx_field_regs.sv
// Module: holds the data field and the instruction field.
// Assumes jump is a single-cycle pulse and that reset is synchronous and active low.
module fx_field_regs #(
    parameter int FIELD_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               df_load,
    input  logic [FIELD_W-1:0] df_next,
    input  logic               jump,
    output logic [FIELD_W-1:0] df_q,
    output logic [FIELD_W-1:0] if_q
);
    // Purpose: data field takes a commanded value, otherwise holds.
    always_ff @(posedge clk) begin
        if (!rst_n)       df_q <= '0;
        else if (df_load) df_q <= df_next;
    end

    // Purpose: instruction field takes the pre-edge data field on a jump.
    always_ff @(posedge clk) begin
        if (!rst_n)    if_q <= '0;
        else if (jump) if_q <= df_q;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (df_q == '0 && if_q == '0));
    a_r2_df_load: assert property (@(posedge clk) disable iff (!rst_n)
        df_load |=> df_q == $past(df_next));
    a_r3_df_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !df_load |=> $stable(df_q));
    a_r5_jump_copy: assert property (@(posedge clk) disable iff (!rst_n)
        jump |=> if_q == $past(df_q));
    a_r6_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (jump && df_load) |=> (if_q == $past(df_q) && df_q == $past(df_next)));
    a_r9_if_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !jump |=> $stable(if_q));
endmodule

// File: rtl/fx_addr_compose.sv
// Module: builds the extended address from a field and the 12-bit address.
// Assumes the all-ones 12-bit address is the I/O port and must map to field 0.
module fx_addr_compose #(
    parameter int ADDR_W  = 12,
    parameter int FIELD_W = 1
) (
    input  field_ext_pkg::field_src_e src,
    input  logic [FIELD_W-1:0]        df,
    input  logic [FIELD_W-1:0]        ifld,
    input  logic [ADDR_W-1:0]         addr,
    output logic [ADDR_W+FIELD_W-1:0] ext_addr
);
    import field_ext_pkg::*;

    localparam logic [ADDR_W-1:0] IO_ADDR = '1;

    logic               is_io;
    logic [FIELD_W-1:0] upper;

    // Purpose: flag the I/O port address so its field is forced to zero.
    always_comb is_io = (addr == IO_ADDR);

    // Purpose: per field bit, pick the source field and mask it for I/O.
    for (genvar b = 0; b < FIELD_W; b++) begin : g_upper
        always_comb upper[b] = !is_io && ((src == SRC_DATA) ? df[b] : ifld[b]);
    end

    // Purpose: place the field above the untouched 12-bit address.
    always_comb ext_addr = {upper, addr};
endmodule

// File: rtl/mem_field_ext.sv
// Module: top of the instruction/data field address extension.
// Assumes port writes arrive with io_wr high for one cycle, and that the
// processor marks indirect data accesses with acc_indirect_i.
module mem_field_ext #(
    parameter int ADDR_W  = 12,
    parameter int FIELD_W = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_wr_i,
    input  logic [ADDR_W-1:0]         io_wdata_i,
    input  logic                      acc_indirect_i,
    input  logic                      jump_i,
    input  logic [ADDR_W-1:0]         addr_i,
    output logic [ADDR_W+FIELD_W-1:0] ext_addr_o
);
    import field_ext_pkg::*;

    localparam int EXT_W = ADDR_W + FIELD_W;

    logic               df_load;
    logic [FIELD_W-1:0] df_next, df_q, if_q;
    field_src_e         src;

    // Purpose: indirect data accesses select the data field.
    always_comb src = acc_indirect_i ? SRC_DATA : SRC_INSTR;

    fx_cmd_decode #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_dec (
        .io_wr(io_wr_i), .wdata(io_wdata_i), .df_load(df_load), .df_next(df_next));

    fx_field_regs #(.FIELD_W(FIELD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .df_load(df_load), .df_next(df_next),
        .jump(jump_i), .df_q(df_q), .if_q(if_q));

    fx_addr_compose #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_comp (
        .src(src), .df(df_q), .ifld(if_q), .addr(addr_i), .ext_addr(ext_addr_o));

    a_r7_io_field_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == '1) |-> (ext_addr_o[EXT_W-1:ADDR_W] == '0));
    a_r8_low_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ext_addr_o[ADDR_W-1:0] == addr_i);
    a_r4_direct_uses_if: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_indirect_i && addr_i != '1) |-> (ext_addr_o[EXT_W-1:ADDR_W] == if_q));
endmodule

// File: tb/tb_mem_field_ext.sv
module tb_mem_field_ext;
    localparam int AW = 12;
    localparam int FW = 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          io_wr = 1'b0;
    logic [AW-1:0] io_wdata = '0;
    logic          ind = 1'b0;
    logic          jmp = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [AW+FW-1:0] ext_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [AW+FW-1:0] exp_q[$];
    string            tag_q[$];

    logic [FW-1:0] df_m = '0;
    logic [FW-1:0] if_m = '0;

    always #4 clk = ~clk;   // 125 MHz

    mem_field_ext #(.ADDR_W(AW), .FIELD_W(FW)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr_i(io_wr), .io_wdata_i(io_wdata),
        .acc_indirect_i(ind), .jump_i(jmp), .addr_i(addr), .ext_addr_o(ext_addr));

    // Driver: one cycle of stimulus, the expected output is pushed first,
    // then the model is advanced to the state after the edge.
    task automatic drive(input logic [AW-1:0] a, input logic i, input logic w,
                         input logic [AW-1:0] wd, input logic j, input string tag);
        logic [FW-1:0] fld;
        @(negedge clk);
        addr = a; ind = i; io_wr = w; io_wdata = wd; jmp = j;
        fld = (a == '1) ? '0 : (i ? df_m : if_m);
        exp_q.push_back({fld, a});
        tag_q.push_back(tag);
        if (j) if_m = df_m;
        if (w && wd[AW-1 -: 2] == 2'b11) df_m = wd[FW-1:0];
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; io_wr = 1'b0; jmp = 1'b0; ind = 1'b0; addr = '0; io_wdata = '0;
        repeat (3) @(negedge clk);
        df_m = '0; if_m = '0;
        rst_n = 1'b1;
    endtask

    // Monitor: compares each expected item with the output mid-cycle.
    always begin
        @(negedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [AW+FW-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (ext_addr !== e) begin
                failures++;
                $display("FAIL %s: ext_addr=%h expected=%h", t, ext_addr, e);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        drive(12'h123, 1'b0, 1'b0, 12'h000, 1'b0, "R1 fetch after reset");
        drive(12'h456, 1'b1, 1'b0, 12'h000, 1'b0, "R1 indirect after reset");
        // R2: field command 0xC01 written through the port
        drive(12'hFFF, 1'b0, 1'b1, 12'hC01, 1'b0, "R7 port access during write");
        drive(12'h010, 1'b1, 1'b0, 12'h000, 1'b0, "R2 indirect sees new DF");
        drive(12'h010, 1'b0, 1'b0, 12'h000, 1'b0, "R4 fetch still IF");
        drive(12'h011, 1'b0, 1'b0, 12'h000, 1'b0, "R8 low bits pass");
        // R3: other device codes and strobe-low words
        drive(12'h012, 1'b0, 1'b1, 12'h800, 1'b0, "R3 i2c code write");
        drive(12'h013, 1'b0, 1'b1, 12'h000, 1'b0, "R3 lcd code write");
        drive(12'h014, 1'b0, 1'b1, 12'h400, 1'b0, "R3 code 01 write");
        drive(12'h015, 1'b0, 1'b0, 12'hC00, 1'b0, "R3 strobe low");
        drive(12'h020, 1'b1, 1'b0, 12'h000, 1'b0, "R3 DF unchanged");
        // R5: jump copies DF into IF
        drive(12'h030, 1'b0, 1'b0, 12'h000, 1'b1, "R5 jump cycle uses old IF");
        drive(12'h031, 1'b0, 1'b0, 12'h000, 1'b0, "R5 fetch after jump");
        // R7: port address from field 1
        drive(12'hFFF, 1'b0, 1'b0, 12'h000, 1'b0, "R7 fetch kind port");
        drive(12'hFFF, 1'b1, 1'b0, 12'h000, 1'b0, "R7 indirect kind port");
        drive(12'hFFE, 1'b0, 1'b0, 12'h000, 1'b0, "R8 neighbour of port");
        // R3: middle bits ignored, field 0 selected
        drive(12'h039, 1'b0, 1'b1, 12'hCFE, 1'b0, "R3 command with stray bits");
        drive(12'h040, 1'b1, 1'b0, 12'h000, 1'b0, "R2 DF back to 0");
        drive(12'h041, 1'b0, 1'b0, 12'h000, 1'b0, "R4 IF kept without jump");
        // R6: write and jump together
        drive(12'h049, 1'b0, 1'b1, 12'hC01, 1'b1, "R6 combined cycle");
        drive(12'h050, 1'b0, 1'b0, 12'h000, 1'b0, "R6 IF took old DF");
        drive(12'h050, 1'b1, 1'b0, 12'h000, 1'b0, "R6 DF took new value");
        // R9: jumps without write, idle hold
        drive(12'h060, 1'b0, 1'b0, 12'h000, 1'b1, "R9 jump cycle");
        drive(12'h061, 1'b0, 1'b0, 12'h000, 1'b1, "R9 second jump");
        drive(12'h062, 1'b0, 1'b0, 12'h000, 1'b0, "R9 IF equals DF");
        for (int k = 0; k < 4; k++)
            drive(12'h070 + 12'(k), 1'b0, 1'b0, 12'h000, 1'b0, "R9 idle hold");
        // R1: reset mid-run clears both fields
        do_reset();
        drive(12'h080, 1'b0, 1'b0, 12'h000, 1'b0, "R1 fetch after second reset");
        drive(12'h081, 1'b1, 1'b0, 12'h000, 1'b0, "R1 indirect after second reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule